// File: doc/BRIEF.md
# Coprocessor Configuration Sequencing Checker

This block is a passive observer placed beside a DMA engine or processing coprocessor that two processors program through register writes. It watches the write strobes, a start strobe and a done strobe, and flags any break of the programming order. The order is: the source and destination addresses are programmed, then the operation is started, and nothing is reprogrammed or restarted until the engine reports completion. The block never drives the engine. It only reports.

A start is legal only when both address registers have been written since the previous start. Every start clears both "written" marks, so each operation must program both addresses again. A busy state is set by start and cleared by done. When start and done arrive in the same cycle, done is taken first. Both processors share the one busy state. Each of the three rules has a sticky flag and a one-cycle pulse. Each rule also keeps the requester ID of its first offender. A done that arrives while idle sets a separate sticky flag.

No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain level or strobe sampled on the rising clock edge.

Top module: `cfg_seq_monitor`

## Requirements
- R1: Right after reset, every rule flag, rule pulse, captured ID and the stray-done flag reads 0.
- R2: A write whose selector equals SRC_SEL (default 0) marks the source address as programmed. A write whose selector equals DST_SEL (default 1) marks the destination as programmed. A start while either mark is missing raises rule 0 (rule_pulse[0], rule_flag[0]) in the cycle after the start.
- R3: Every start clears both address marks. A second start with no new address writes therefore raises rule 0.
- R4: Busy is set by start and cleared by done. A start while busy raises rule 1, unless done arrives in the same cycle, because done is processed first.
- R5: A configuration write of any selector while busy raises rule 2. A write in the cycle of done is not a violation. A write in the cycle of start is not a violation, and it counts toward the next operation's programming.
- R6: A done while not busy sets stray_done. A done while busy leaves stray_done unchanged.
- R7: Rule flags and stray_done stay set until reset. A rule pulse is high for exactly the one cycle after each offending input cycle.
- R8: Each rule captures, in rule_id[r*ID_W +: ID_W], the requester ID of its first offender and holds it afterwards. Rules 0 and 1 take start_id. Rule 2 takes wr_id.
- R9: Writes and starts from either requester act on the same address marks and the same busy state.
- R10: A single start that is both unarmed and overlapping raises rules 0 and 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration register write strobe |
| wr_sel | input | SEL_W | Register selector of the write |
| wr_id | input | ID_W | Requester issuing the write |
| start | input | 1 | Operation start strobe |
| start_id | input | ID_W | Requester issuing the start |
| done | input | 1 | End-of-operation strobe from the engine |
| rule_flag | output | 3 | Sticky violation flags: bit 0 unarmed start, bit 1 start while busy, bit 2 write while busy |
| rule_pulse | output | 3 | One-cycle violation pulses, same bit order |
| rule_id | output | 3*ID_W | First offender ID per rule, rule r at bits r*ID_W upward |
| stray_done | output | 1 | Sticky flag for a done while idle |

## Verification
Two functions can collide in one cycle: done can arrive with a new start, and done can arrive with a configuration write. Both give a violation if done is not processed first. The bench drives each pair in one cycle while an operation is running. It expects rule 1 to stay low when done comes with the start, and rule 2 to stay low when done comes with the write. A second collision is a write issued in the same cycle as a start. The bench expects no rule 2 violation for it, and expects that write to arm the following start.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int NUM_RULES = 3;
  typedef enum int {
    RULE_UNARMED  = 0,
    RULE_OVERLAP  = 1,
    RULE_RECONFIG = 2
  } rule_e;
endpackage

// File: rtl/cfgseq_arm.sv
module cfgseq_arm #(
  parameter int SEL_W   = 2,
  parameter int SRC_SEL = 0,
  parameter int DST_SEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             start,
  output logic             armed
);
  logic src_ok, dst_ok;
  logic hit_src, hit_dst;

  assign hit_src = wr_en && (wr_sel == SEL_W'(SRC_SEL));
  assign hit_dst = wr_en && (wr_sel == SEL_W'(DST_SEL));

  // start clears first; a write in the same cycle belongs to the next operation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_ok <= 1'b0;
      dst_ok <= 1'b0;
    end else begin
      src_ok <= hit_src | (src_ok & ~start);
      dst_ok <= hit_dst | (dst_ok & ~start);
    end
  end

  assign armed = src_ok & dst_ok;

  // R3: a start without a simultaneous write leaves the block unarmed
  a_r3_start_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    start && !wr_en |=> !armed);
  // R2: once both marks are set and no start occurs, the block stays armed
  a_r2_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start |=> armed);
endmodule

// File: rtl/cfgseq_busy.sv
module cfgseq_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy_eff,
  output logic stray_done
);
  logic busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      stray_done <= 1'b0;
    end else begin
      busy       <= start | (busy & ~done);
      stray_done <= stray_done | (done & ~busy);
    end
  end

  // done is taken first: a done in this cycle ends the running operation
  assign busy_eff = busy & ~done;

  // R4: start leaves the engine busy
  a_r4_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R4: done without a new start returns to idle
  a_r4_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !busy);
  // R6: an idle done sets the stray flag
  a_r6_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
    done && !busy |=> stray_done);
  // R7: the stray flag is sticky
  a_r7_stray_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stray_done |=> stray_done);
endmodule

// File: rtl/cfgseq_recorder.sv
module cfgseq_recorder #(
  parameter int ID_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [ID_W-1:0] hit_id,
  output logic            flag,
  output logic            pulse,
  output logic [ID_W-1:0] first_id
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      pulse    <= 1'b0;
      first_id <= '0;
    end else begin
      pulse <= hit;
      flag  <= flag | hit;
      if (hit && !flag) first_id <= hit_id;
    end
  end

  // R7: sticky flag never drops
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);
  // R7: every pulse is accompanied by its flag
  a_r7_pulse_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> flag);
  // R8: the first offender ID is frozen once recorded
  a_r8_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(first_id));
endmodule

// File: rtl/cfg_seq_monitor.sv
module cfg_seq_monitor
  import cfgseq_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int ID_W    = 1,
  parameter int SRC_SEL = 0,
  parameter int DST_SEL = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [ID_W-1:0]           wr_id,
  input  logic                      start,
  input  logic [ID_W-1:0]           start_id,
  input  logic                      done,
  output logic [NUM_RULES-1:0]      rule_flag,
  output logic [NUM_RULES-1:0]      rule_pulse,
  output logic [NUM_RULES*ID_W-1:0] rule_id,
  output logic                      stray_done
);
  logic armed, busy_eff;
  logic [NUM_RULES-1:0] hit;
  logic [ID_W-1:0]      hit_id [NUM_RULES];

  cfgseq_arm #(.SEL_W(SEL_W), .SRC_SEL(SRC_SEL), .DST_SEL(DST_SEL)) u_arm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .start(start), .armed(armed));

  cfgseq_busy u_busy (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .busy_eff(busy_eff), .stray_done(stray_done));

  // rule event detection
  always_comb begin
    hit[RULE_UNARMED]     = start & ~armed;
    hit_id[RULE_UNARMED]  = start_id;
    hit[RULE_OVERLAP]     = start & busy_eff;
    hit_id[RULE_OVERLAP]  = start_id;
    hit[RULE_RECONFIG]    = wr_en & busy_eff;
    hit_id[RULE_RECONFIG] = wr_id;
  end

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    cfgseq_recorder #(.ID_W(ID_W)) u_rec (
      .clk(clk), .rst_n(rst_n), .hit(hit[r]), .hit_id(hit_id[r]),
      .flag(rule_flag[r]), .pulse(rule_pulse[r]),
      .first_id(rule_id[r*ID_W +: ID_W]));
  end

  // R10: a simultaneous unarmed and overlapping start shows both pulses together
  a_r10_dual_rule: assert property (@(posedge clk) disable iff (!rst_n)
    start && !armed && busy_eff |=> rule_pulse[RULE_UNARMED] && rule_pulse[RULE_OVERLAP]);
  // R5: a write while idle never raises the reconfiguration rule
  a_r5_idle_write_ok: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy_eff |=> !rule_pulse[RULE_RECONFIG]);
endmodule

// File: tb/cfg_seq_monitor_test.sv
`timescale 1ns/1ps
module cfg_seq_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic       wr_id = 1'b0;
  logic       start = 1'b0;
  logic       start_id = 1'b0;
  logic       done = 1'b0;
  logic [2:0] rule_flag, rule_pulse, rule_id;
  logic       stray_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [2:0] pulse;
    logic [2:0] flag;
    logic [2:0] ids;
    logic       stray;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];

  cfg_seq_monitor uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_id(wr_id),
    .start(start), .start_id(start_id), .done(done),
    .rule_flag(rule_flag), .rule_pulse(rule_pulse), .rule_id(rule_id),
    .stray_done(stray_done));

  always #2.5 clk = ~clk;

  // monitor: compares each result against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        obs_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{pulse: rule_pulse, flag: rule_flag, ids: rule_id, stray: stray_done};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got pulse=%b flag=%b id=%b stray=%b exp pulse=%b flag=%b id=%b stray=%b",
                   t, a.pulse, a.flag, a.ids, a.stray, e.pulse, e.flag, e.ids, e.stray);
        end
      end
    end
  end

  // driver: applies one cycle of stimulus and queues what must follow
  task automatic step(input logic w, input logic [1:0] s, input logic wid,
                      input logic st, input logic sid, input logic dn,
                      input logic [2:0] ep, input logic [2:0] ef,
                      input logic [2:0] ei, input logic es, input string tag);
    @(negedge clk);
    wr_en = w; wr_sel = s; wr_id = wid;
    start = st; start_id = sid; done = dn;
    exp_q.push_back('{pulse: ep, flag: ef, ids: ei, stray: es});
    tag_q.push_back(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //   wr sel id  st sid dn  pulse   flag    ids     stray
    step(0, 0, 0, 0, 0, 0, 3'b000, 3'b000, 3'b000, 0, "R1 reset state");
    step(1, 0, 1, 0, 0, 0, 3'b000, 3'b000, 3'b000, 0, "R2 src write idle");
    step(1, 3, 0, 0, 0, 0, 3'b000, 3'b000, 3'b000, 0, "R5 other reg write idle");
    step(0, 0, 0, 1, 1, 0, 3'b001, 3'b001, 3'b001, 0, "R2 start missing dst");
    step(1, 2, 1, 0, 0, 0, 3'b100, 3'b101, 3'b101, 0, "R5 R9 write while busy by req1");
    step(1, 0, 0, 0, 0, 1, 3'b000, 3'b101, 3'b101, 0, "R5 write with done not violation");
    step(1, 1, 0, 0, 0, 0, 3'b000, 3'b101, 3'b101, 0, "R2 dst write");
    step(0, 0, 0, 1, 0, 0, 3'b000, 3'b101, 3'b101, 0, "R2 armed start clean");
    step(0, 0, 0, 1, 0, 0, 3'b011, 3'b111, 3'b101, 0, "R10 R3 R4 R8 overlap and unarmed");
    step(0, 0, 0, 1, 1, 1, 3'b001, 3'b111, 3'b101, 0, "R4 start with done no overlap");
    step(0, 0, 0, 0, 0, 1, 3'b000, 3'b111, 3'b101, 0, "R6 done while busy");
    step(0, 0, 0, 0, 0, 1, 3'b000, 3'b111, 3'b101, 1, "R6 stray done");
    step(0, 0, 0, 0, 0, 0, 3'b000, 3'b111, 3'b101, 1, "R7 flags held pulses low");
    step(1, 0, 1, 0, 0, 0, 3'b000, 3'b111, 3'b101, 1, "R9 src by req1");
    step(1, 1, 0, 1, 0, 0, 3'b001, 3'b111, 3'b101, 1, "R5 same-cycle dst not counted");
    step(0, 0, 0, 0, 0, 1, 3'b000, 3'b111, 3'b101, 1, "R4 done ends op");
    step(1, 0, 0, 0, 0, 0, 3'b000, 3'b111, 3'b101, 1, "R2 src write");
    step(0, 0, 0, 1, 1, 0, 3'b000, 3'b111, 3'b101, 1, "R5 start-cycle dst arms next start");
    step(1, 3, 0, 0, 0, 0, 3'b100, 3'b111, 3'b101, 1, "R8 later offender id held");
    step(0, 0, 0, 0, 0, 1, 3'b000, 3'b111, 3'b101, 1, "R7 pulse one cycle");
    step(0, 0, 0, 0, 0, 0, 3'b000, 3'b111, 3'b101, 1, "R7 idle hold");
    @(negedge clk);
    wr_en = 0; start = 0; done = 0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule